// File: doc/BRIEF.md
# I2C Bus Clock Phase Strobe Generator

This block divides a fast system clock down to a reference serial clock for an I2C bus engine. It also marks the middle of each clock half with a one-cycle strobe. A bit-level engine uses the low-half strobe to move the data line, including the setup for start and stop conditions. It uses the high-half strobe to sample the data line or to create the start and stop edges. Because both strobes sit at the centre of their half, the data line has a quarter period of margin on each side of every clock edge.

The serial clock period is a parameter given in system clocks. The default of 500 gives 100 kHz from a 50 MHz system clock. The two halves are equal. The reset input is asserted asynchronously and released through a two-stage synchronizer. While in reset the reference clock sits high, matching an idle bus. Gating the clock onto the bus pin and driving the data line are left to the engine.

Top module: `scl_phase_strobe_gen`

## Requirements
- R1: While rst_n is low, scl_ref is 1 and both strobes are 0. This takes effect without waiting for a clock edge.
- R2: Let k be the number of rising clock edges with rst_n high since rst_n last rose, minus 2, floored at 0. With P = SYS_CLKS_PER_SCL and H = P/2, scl_ref is 1 when (k mod P) < H and 0 otherwise.
- R3: capt_stb is 1 exactly when (k mod P) equals H/2, rounded down. This is the middle of the high half.
- R4: xfer_stb is 1 exactly when (k mod P) equals H + H/2, rounded down. This is the middle of the low half.
- R5: Each strobe is high for exactly one system clock cycle at a time.
- R6: The two strobes are never high in the same cycle. They alternate strictly, and capt_stb comes first after reset.
- R7: Consecutive capt_stb pulses are exactly P system clocks apart, and so are consecutive xfer_stb pulses.
- R8: P must be even and at least 4. The rules of R2 to R4 hold when H is odd, for example with P = 10, where the strobe offsets are 2 and 7.
- R9: If rst_n is asserted during operation, the outputs return to the R1 state at once. After release, the sequence restarts from k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Asserted asynchronously, released synchronously |
| scl_ref | output | 1 | Reference serial clock level |
| xfer_stb | output | 1 | One-cycle pulse at the middle of the low half. The data line may change here |
| capt_stb | output | 1 | One-cycle pulse at the middle of the high half. The data line is sampled here |

## Verification
The assertions check several properties on every cycle:
- The two strobes are never high together.
- Each strobe is one cycle wide.
- Capture and transfer strobes alternate.
- Each strobe falls inside its own clock level.
- The level changes only when the half counter wraps.

Only the bench's scenarios can show the exact cycle positions. These are the offset of each strobe inside the period, the period length, and the two-edge delay after reset release. The bench's reference model also covers the restart after a mid-run reset and the rounding of an odd half-period, using a second, small instance.

// File: rtl/scl_strobe_pkg.sv
package scl_strobe_pkg;

  // Level of the reference serial clock; also indexes the strobe generate loop
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  function automatic int unsigned half_of(input int unsigned period);
    return period / 2;
  endfunction

  function automatic int unsigned mid_of(input int unsigned period);
    return (period / 2) / 2;
  endfunction

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/scl_half_counter.sv
module scl_half_counter
  import scl_strobe_pkg::*;
#(
  parameter  int unsigned HALF = 250,
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output phase_e        ph_q,
  output phase_e        ph_d
);

  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
    if (wrap) begin
      ph_d = (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
    end else begin
      ph_d = ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_HIGH;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  // R2
  level_change_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |-> ($past(cnt_q) == LAST));

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/scl_mid_strobe.sv
module scl_mid_strobe
  import scl_strobe_pkg::*;
#(
  parameter  int unsigned HALF = 250,
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int unsigned MID  = HALF / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_d,
  input  phase_e        ph_d,
  output logic          xfer_q,
  output logic          capt_q
);

  // index 0 = low half (transfer), index 1 = high half (capture)
  logic [1:0] stb_d;
  logic [1:0] stb_q;

  for (genvar g = 0; g < 2; g++) begin : g_stb
    always_comb begin
      stb_d[g] = (ph_d == phase_e'(g)) && (cnt_d == CW'(MID));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stb_q[g] <= 1'b0;
      end else begin
        stb_q[g] <= stb_d[g];
      end
    end
  end

  assign xfer_q = stb_q[0];
  assign capt_q = stb_q[1];

  // assertion-side record of which strobe fired last (1 = capture)
  logic last_capt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_capt_q <= 1'b0;
    end else if (capt_q) begin
      last_capt_q <= 1'b1;
    end else if (xfer_q) begin
      last_capt_q <= 1'b0;
    end
  end

  // R6
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_q && capt_q));

  // R5
  xfer_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q |=> !xfer_q);

  // R5
  capt_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capt_q |=> !capt_q);

  // R6
  capt_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capt_q |-> !last_capt_q);

  // R6
  xfer_after_capt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q |-> last_capt_q);

endmodule

// File: rtl/scl_phase_strobe_gen.sv
module scl_phase_strobe_gen
  import scl_strobe_pkg::*;
#(
  parameter int unsigned SYS_CLKS_PER_SCL = 500
) (
  input  logic clk,
  input  logic rst_n,
  output logic scl_ref,
  output logic xfer_stb,
  output logic capt_stb
);

  localparam int unsigned HALF = half_of(SYS_CLKS_PER_SCL);
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  // R8
  if ((SYS_CLKS_PER_SCL % 2 != 0) || (SYS_CLKS_PER_SCL < 4)) begin : g_bad_period
    $error("SYS_CLKS_PER_SCL must be even and at least 4");
  end

  logic          srst_n;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  phase_e        ph_q;
  phase_e        ph_d;

  scl_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  scl_half_counter #(
    .HALF (HALF)
  ) u_counter (
    .clk   (clk),
    .rst_n (srst_n),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d),
    .ph_q  (ph_q),
    .ph_d  (ph_d)
  );

  scl_mid_strobe #(
    .HALF (HALF)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (srst_n),
    .cnt_d  (cnt_d),
    .ph_d   (ph_d),
    .xfer_q (xfer_stb),
    .capt_q (capt_stb)
  );

  assign scl_ref = (ph_q == PH_HIGH);

  // R3
  capt_in_high_chk: assert property (@(posedge clk) disable iff (!srst_n)
    capt_stb |-> scl_ref);

  // R4
  xfer_in_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    xfer_stb |-> !scl_ref);

endmodule

// File: tb/tb_scl_phase_strobe_gen.sv
module tb_scl_phase_strobe_gen;

  localparam int P_BIG   = 500;
  localparam int P_SMALL = 10;

  logic clk;
  logic rst_n;
  logic scl_a, xfer_a, capt_a;
  logic scl_b, xfer_b, capt_b;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  bit done   = 0;
  string lvl_tag = "R2";

  // width and spacing history for the large instance
  logic prev_capt_a = 1'b0;
  logic prev_xfer_a = 1'b0;
  int   last_capt_k = -1;
  int   last_xfer_k = -1;

  scl_phase_strobe_gen #(.SYS_CLKS_PER_SCL(P_BIG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_ref(scl_a), .xfer_stb(xfer_a), .capt_stb(capt_a));

  scl_phase_strobe_gen #(.SYS_CLKS_PER_SCL(P_SMALL)) dut_small (
    .clk(clk), .rst_n(rst_n), .scl_ref(scl_b), .xfer_stb(xfer_b), .capt_stb(capt_b));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at time %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int pos_k();
    return (edges > 2) ? edges - 2 : 0;
  endfunction

  task automatic compare_all();
    int k  = pos_k();
    int ma = k % P_BIG;
    int mb = k % P_SMALL;
    check(lvl_tag, scl_a, ma < P_BIG / 2);
    check("R3", capt_a, ma == (P_BIG / 2) / 2);
    check("R4", xfer_a, ma == P_BIG / 2 + (P_BIG / 2) / 2);
    check("R8", scl_b, mb < P_SMALL / 2);
    check("R8", capt_b, mb == 2);
    check("R8", xfer_b, mb == 7);
    check("R6", capt_a && xfer_a, 1'b0);
    if (prev_capt_a) check("R5", capt_a, 1'b0);
    if (prev_xfer_a) check("R5", xfer_a, 1'b0);
    if (capt_a) begin
      if (last_capt_k >= 0) check("R7", (k - last_capt_k) == P_BIG, 1'b1);
      last_capt_k = k;
    end
    if (xfer_a) begin
      if (last_xfer_k >= 0) check("R7", (k - last_xfer_k) == P_BIG, 1'b1);
      last_xfer_k = k;
    end
    prev_capt_a = capt_a;
    prev_xfer_a = xfer_a;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (rst_n) edges++;
      else edges = 0;
      #1;
      compare_all();
    end
  endtask

  task automatic check_reset_state(input string tag);
    check(tag, scl_a, 1'b1);
    check(tag, capt_a, 1'b0);
    check(tag, xfer_a, 1'b0);
    check(tag, scl_b, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    run(1600);
    // reset in mid run while scl is low (k = 1598, mod 500 = 98 ... high phase) – wait for low
    run(160);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("R9");
    last_capt_k = -1;
    last_xfer_k = -1;
    run(5);
    check_reset_state("R1");
    @(negedge clk);
    rst_n = 1'b1;
    lvl_tag = "R9";
    run(1300);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule